// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error and Break Detection

This block is the receive half of an asynchronous serial port. The serial line `rxd` first passes through a synchronizer chain. A falling edge then starts a character. The start bit is confirmed at its midpoint, and after that the data bits, the optional parity bit and one stop bit are each sampled at mid-bit. One bit lasts `divisor + 1` clock cycles. Data bits arrive least significant bit first.

When the stop bit has been sampled, the assembled character appears on `rx_data` with a one-cycle `rx_valid` strobe. The framing and parity verdicts for that character are strobed in the same cycle. The output has no ready signal and applies no back-pressure. Every character is delivered as soon as it completes, even when it carries an error, and a consumer that misses the strobe loses the character.

A separate detector watches for the line held low for longer than one whole character time and raises a single `break_det` pulse. After a break, the receiver does not arm for a new start bit until the line has returned high.

Top module: `serial_rx`

## Requirements
- R1: After reset, `rx_valid`, `parity_err`, `frame_err`, `break_det` and `rx_data` are 0. The synchronizer chain of `SYNC_STAGES` flops resets to 1, so an idle-high line produces no strobe.
- R2: One bit period is `divisor + 1` clock cycles, and each bit is sampled near its midpoint. Characters are received correctly at more than one divisor value.
- R3: Data bits are assembled least significant bit first. The character is presented on `rx_data` with `rx_valid` high for exactly one cycle.
- R4: A low pulse on `rxd` that has returned to 1 by the middle of the start bit is discarded, and no character is produced.
- R5: With `PARITY` set to even (1), the expected parity bit is the XOR of the data bits. With `PARITY` set to odd (2), it is the inverse of that XOR. A mismatch raises `parity_err` together with `rx_valid`. With `PARITY` set to none (0), no parity bit is expected and `parity_err` stays 0.
- R6: If the first stop bit is sampled as 0, `frame_err` is raised together with `rx_valid`, and the character is still delivered.
- R7: Only the first stop bit is examined, whatever `STOP_BITS` is. A character that follows a single stop bit immediately is received correctly.
- R8: No back-pressure: every completed character is presented, including one that follows a character nobody consumed.
- R9: `break_det` pulses once, for one cycle, when the synchronized line has been 0 for more than (1 + `DATA_W` + parity bits + `STOP_BITS`) × (`divisor` + 1) consecutive cycles. A low period of exactly that length gives no pulse.
- R10: After a break, no new character is started while the line stays low. Reception resumes once the line has been high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| divisor | input | DIV_W | Bit period minus one, in clock cycles |
| rx_data | output | DATA_W | Last received character |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new character |
| parity_err | output | 1 | Parity mismatch on the strobed character |
| frame_err | output | 1 | Stop bit sampled low on the strobed character |
| break_det | output | 1 | One-cycle strobe: line low longer than one character time |

## Verification
The receiver gets characters of mixed bit density (0xA5, 0x01, 0x80, 0xFF, 0x3C) at two divisor values. Wrong bit ordering or a wrong bit period shows up as corrupted data. Frames with a deliberately inverted parity bit or a low stop bit must still deliver their data while the matching error strobe rises. Back-to-back frames with a single stop bit show that the extra configured stop bit is never awaited. A short start glitch tells a confirmed start from a false one. Two low periods, one exactly a character time and one longer, mark the boundary of break detection, and a long hold checks that nothing restarts until the line rises.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2
  } par_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b1;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_timer.sv
module serial_rx_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             load_half,
  input  logic             load_full,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load_half)      cnt <= divisor >> 1;
    else if (load_full)      cnt <= divisor;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/serial_rx_break.sv
module serial_rx_break #(
  parameter int DIV_W     = 16,
  parameter int CHAR_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  input  logic [DIV_W-1:0] divisor,
  output logic             brk
);
  localparam int CW = DIV_W + $clog2(CHAR_BITS + 1) + 1;

  logic [CW-1:0] limit;
  logic [CW-1:0] low_cnt;

  assign limit = CW'(CHAR_BITS) * (CW'(divisor) + CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      brk     <= 1'b0;
    end else begin
      brk <= !line && (low_cnt == limit);
      if (line)                 low_cnt <= '0;
      else if (low_cnt <= limit) low_cnt <= low_cnt + 1'b1;
    end
  end

  // R9: one pulse per low period
  a_r9_break_single: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !brk);
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PARITY      = 1,
  parameter int STOP_BITS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [DIV_W-1:0]  divisor,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              parity_err,
  output logic              frame_err,
  output logic              break_det
);
  localparam bit HAS_PAR   = (PARITY != 0);
  localparam int CHAR_BITS = 1 + DATA_W + (HAS_PAR ? 1 : 0) + STOP_BITS;
  localparam int IDX_W     = $clog2(DATA_W + 1);

  rx_state_e         state;
  logic              rxs, rxs_q, fall, tick, load_half, load_full;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit, exp_par;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxs));

  serial_rx_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .divisor(divisor),
    .load_half(load_half), .load_full(load_full), .tick(tick));

  serial_rx_break #(.DIV_W(DIV_W), .CHAR_BITS(CHAR_BITS)) u_break (
    .clk(clk), .rst_n(rst_n), .line(rxs), .divisor(divisor), .brk(break_det));

  assign fall      = rxs_q && !rxs;
  assign load_half = (state == S_IDLE) && fall;
  assign load_full = tick && (((state == S_START) && !rxs) ||
                              (state == S_DATA) || (state == S_PAR));

  if (PARITY == int'(PAR_ODD)) begin : g_odd
    assign exp_par = ~^shreg;
  end else begin : g_even
    assign exp_par = ^shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rxs_q      <= 1'b1;
      bit_idx    <= '0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      rxs_q      <= rxs;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      case (state)
        S_IDLE:  if (fall) state <= S_START;
        S_START: if (tick) begin
          if (rxs) state <= S_IDLE;
          else begin
            state   <= S_DATA;
            bit_idx <= '0;
          end
        end
        S_DATA:  if (tick) begin
          shreg <= {rxs, shreg[DATA_W-1:1]};
          if (bit_idx == IDX_W'(DATA_W - 1)) state <= HAS_PAR ? S_PAR : S_STOP;
          else bit_idx <= bit_idx + 1'b1;
        end
        S_PAR:   if (tick) begin
          par_bit <= rxs;
          state   <= S_STOP;
        end
        S_STOP:  if (tick) begin
          rx_valid   <= 1'b1;
          rx_data    <= shreg;
          frame_err  <= !rxs;
          parity_err <= HAS_PAR && (par_bit != exp_par);
          state      <= S_IDLE;
        end
        S_HOLD:  if (rxs) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (break_det) state <= S_HOLD;
    end
  end

  // R3: the data strobe lasts one cycle
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R6: the framing verdict accompanies a delivered character
  a_r6_ferr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> rx_valid);
  // R5: the parity verdict accompanies a delivered character
  a_r5_perr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> rx_valid);
  // R10: after a break the receiver stays parked while the line is low
  a_r10_hold_until_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) && !rxs && !break_det |=> (state == S_HOLD));
endmodule

// File: tb/serial_rx_bench.sv
module serial_rx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] divisor = 16'd9;
  logic [7:0]  rx_data;
  logic        rx_valid, parity_err, frame_err, break_det;

  int vecs = 0;
  int errs = 0;
  int valid_seen = 0;
  int brk_seen = 0;
  logic [9:0] expq[$];

  always #2.5 clk = ~clk;

  serial_rx u_serial_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .divisor(divisor),
    .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
    .frame_err(frame_err), .break_det(break_det));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int cycles);
    @(posedge clk);
    rxd <= v;
    repeat (cycles - 1) @(posedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit flip_par,
                           input logic stop_v, input int nstop);
    int per;
    per = int'(divisor) + 1;
    expq.push_back({d, flip_par, ~stop_v});
    hold_line(1'b0, per);
    for (int i = 0; i < 8; i++) hold_line(d[i], per);
    hold_line((^d) ^ flip_par, per);
    hold_line(stop_v, per);
    for (int i = 1; i < nstop; i++) hold_line(1'b1, per);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && break_det) brk_seen++;
    if (rst_n && rx_valid) begin
      valid_seen++;
      if (expq.size() == 0) begin
        chk(1'b0, "R8", "unexpected character", int'(rx_data), 0);
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        chk({rx_data, parity_err, frame_err} == e, "R3/R5/R6",
            "char{data,perr,ferr}", int'({rx_data, parity_err, frame_err}), int'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int v0;
    int b0;
    repeat (4) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    chk({rx_valid, parity_err, frame_err, break_det} == 4'b0, "R1", "reset strobes",
        int'({rx_valid, parity_err, frame_err, break_det}), 0);
    chk(rx_data == 8'h00, "R1", "reset data", int'(rx_data), 0);
    repeat (50) @(posedge clk);
    chk(valid_seen == 0 && brk_seen == 0, "R1", "idle line strobes", valid_seen + brk_seen, 0);

    // R2/R3: varied bit patterns at divisor 9, two stop bits
    send_char(8'hA5, 1'b0, 1'b1, 2);
    send_char(8'h01, 1'b0, 1'b1, 2);
    send_char(8'h80, 1'b0, 1'b1, 2);
    // R5: inverted parity, R6: low stop bit
    send_char(8'h3C, 1'b1, 1'b1, 2);
    send_char(8'hFF, 1'b0, 1'b0, 1);
    hold_line(1'b1, 40);
    // R7/R8: back-to-back frames with a single stop bit, none consumed
    send_char(8'h5A, 1'b0, 1'b1, 1);
    send_char(8'hC3, 1'b0, 1'b1, 1);
    send_char(8'h7E, 1'b0, 1'b1, 1);
    hold_line(1'b1, 40);
    chk(valid_seen == 8, "R8", "characters delivered", valid_seen, 8);

    // R4: short start glitch
    v0 = valid_seen;
    hold_line(1'b0, 2);
    hold_line(1'b1, 200);
    chk(valid_seen == v0, "R4", "false start ignored", valid_seen - v0, 0);

    // R2: different rate
    divisor = 16'd4;
    hold_line(1'b1, 10);
    send_char(8'h96, 1'b0, 1'b1, 2);
    send_char(8'h00, 1'b0, 1'b1, 2);
    hold_line(1'b1, 30);
    chk(valid_seen == v0 + 2, "R2", "chars at divisor 4", valid_seen - v0, 2);
    divisor = 16'd9;
    hold_line(1'b1, 20);

    // R9: low for exactly one character time (12 bits * 10 cycles): no break
    b0 = brk_seen;
    expq.push_back({8'h00, 1'b0, 1'b1});
    hold_line(1'b0, 120);
    hold_line(1'b1, 60);
    chk(brk_seen == b0, "R9", "no break at exact char time", brk_seen - b0, 0);

    // R9/R10: long low: one break, one zero char, nothing more while low
    v0 = valid_seen;
    expq.push_back({8'h00, 1'b0, 1'b1});
    hold_line(1'b0, 400);
    chk(brk_seen == b0 + 1, "R9", "single break pulse", brk_seen - b0, 1);
    chk(valid_seen == v0 + 1, "R10", "no restart while low", valid_seen - v0, 1);
    hold_line(1'b1, 30);
    send_char(8'h4B, 1'b0, 1'b1, 2);
    hold_line(1'b1, 40);
    chk(valid_seen == v0 + 2, "R10", "resume after break", valid_seen - v0, 2);
    chk(expq.size() == 0, "R3", "pending expected chars", expq.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule